// File: doc/BRIEF.md
# Cascaded Two-Stage Interrupt Arbiter

This block joins two eight-line interrupt controller cores into one sixteen-source arbiter. Lines 0..7 reach the first-stage (primary) core. Lines 8..15 reach the second-stage (secondary) core. When the secondary core has a request it may deliver, it raises one latched edge request on primary input 2. Primary line 2 from the pins is not used. The block keeps one sticky "interrupt pending" flag toward the processor. The flag is set whenever the primary core can deliver a request.

The processor raises `ack_req` to take an interrupt. If the pending flag is set, the flag is cleared and the acknowledge runs through both cores in the same cycle. One cycle later the block reports the vector (base plus line) and the global line number. The acknowledge also covers the cases where a core has nothing left to deliver.

Software reaches the cores through a byte-wide register port. For controller registers, address bit 7 selects the core and address bit 0 selects the register. For the trigger-mode registers, address bit 0 selects the core. Any access whose size code is not "one byte" is ignored.

Top module: `pic_cascade`

## Requirements
- R1: After reset, `pend_o` and `ack_valid` are 0, and the primary core's request register and mask register read as 0x00.
- R2: A rising edge on a primary line sets `pend_o` two cycles later. The acknowledge that follows has `ack_hit`=1, `ack_vec` = primary base + line and `ack_gsi` = line. `pend_o` is 0 in the cycle after an acknowledge that found it set. Among several requests, the lowest line number wins.
- R3: A secondary request reaches primary input 2 as an edge. Acknowledging primary input 2 also acknowledges the secondary core. The result is then `ack_vec` = secondary base + secondary line and `ack_gsi` = secondary line + 8. Both cores record the line in service (in-service bit 2 on the primary).
- R4: If the primary resolves to input 2 but the secondary has nothing deliverable, the result is secondary base + 7 with `ack_gsi` = 15. The secondary in-service register is not changed.
- R5: If the primary has nothing deliverable at acknowledge time, the result is primary base + 7 with `ack_gsi` = 7. The primary in-service register is not changed.
- R6: `ack_req` while `pend_o` is 0 gives `ack_valid`=1 with `ack_hit`=0, `ack_vec`=0 and `ack_gsi`=0, and changes no core state.
- R7: An initialization command (control write with data bit 4 set) to either core makes `pend_o` 0 in the following cycle.
- R8: With special nesting set on the primary (bit 4 of the last setup byte), the primary ignores its in-service bit 2 when it computes its current priority. A higher-priority secondary request can then pass while another secondary line is in service. Without special nesting, that request is blocked.
- R9: A poll read of the secondary clears the polled line in the secondary. It also clears bit 2 of the primary's request and in-service registers. The poll read returns the line number, or 0x07 when no request is deliverable. A poll is armed by the control byte 0x0C.
- R10: For controller access, `acc_addr[7]` selects the core (0 primary, 1 secondary), and with `acc_addr[0]`=1 a byte written after setup is the mask register. For trigger access (`acc_trig`=1), `acc_addr[0]` selects the core, and writes are limited to 0xF8 (primary) and 0xDE (secondary).
- R11: An access with `acc_size` other than 0 changes no register. A read of this kind returns 0x00.
- R12: `pend_o` is set again as soon as a state change makes a primary request deliverable, for example after a non-specific end-of-interrupt (control byte 0x20).
- R13: Programming encodings, in order:
  - Setup is a control write with bit 4 set. Bit 0 of that byte says whether a fourth byte follows.
  - The next byte gives the vector base in bits 7:3. A third byte follows, and then the optional fourth byte.
  - The control byte 0x0A selects the request register for control-address reads. The control byte 0x0B selects the in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt lines; 7:0 primary (line 2 unused), 15:8 secondary |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 write, 0 read |
| acc_trig | input | 1 | 1 selects the trigger-mode registers |
| acc_size | input | 2 | Access size code; only 0 (one byte) is accepted |
| acc_addr | input | 8 | Access address; bit 7 picks the core, bit 0 picks the register |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid while a read is presented |
| ack_req | input | 1 | Read-and-clear of the pending flag plus acknowledge |
| pend_o | output | 1 | Interrupt pending toward the processor |
| ack_valid | output | 1 | Acknowledge result valid (one cycle after `ack_req`) |
| ack_hit | output | 1 | 1 if the pending flag was set when acknowledged |
| ack_vec | output | 8 | Resulting vector |
| ack_gsi | output | 4 | Resulting global line number |

## Verification
Each acknowledge pattern is tried separately, so that any wrong branch in the resolution chain shows up:
- a single primary edge and two competing primary edges show the direct path and its priority order;
- a secondary edge shows the cascade chaining;
- a secondary level line that drops before the acknowledge shows the secondary spurious path;
- a primary level line that drops shows the primary spurious path.

Two identical nested secondary sequences are run, one with special nesting and one without. A changed blocking outcome can only come from the in-service bit 2 handling. A poll of the secondary followed by a read of the primary request register shows the cross-core clear. A repeat poll with nothing deliverable shows the 0x07 fallback.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int LINES     = 8;
    localparam int IDX_W     = $clog2(LINES);
    localparam int BASE_W    = 8 - IDX_W;
    localparam int PRIO_W    = IDX_W + 1;
    localparam int CASC_LINE = 2;
    localparam logic [PRIO_W-1:0] NO_PRIO = PRIO_W'(LINES);

    typedef struct packed {
        logic [LINES-1:0]  irr;
        logic [LINES-1:0]  imr;
        logic [LINES-1:0]  isr;
        logic [LINES-1:0]  trig;
        logic [LINES-1:0]  last;
        logic [IDX_W-1:0]  rbase;
        logic [BASE_W-1:0] vbase;
        logic              aeoi;
        logic              rot_aeoi;
        logic              sfnm;
        logic              poll;
        logic              rsel;
        logic              init4;
        logic [1:0]        init_st;
    } core_st_t;

    typedef struct packed {
        logic              pend;
        logic              ack_valid;
        logic              ack_hit;
        logic [7:0]        vec;
        logic [IDX_W:0]    gsi;
    } arb_st_t;

    // Rank of the first set bit of m, scanning upward from rotation base;
    // LINES when m is empty.
    function automatic logic [PRIO_W-1:0] prio_of(input logic [LINES-1:0] m,
                                                  input logic [IDX_W-1:0] base);
        logic [PRIO_W-1:0] p;
        logic [IDX_W-1:0]  idx;
        p = NO_PRIO;
        for (int i = LINES - 1; i >= 0; i--) begin
            idx = base + IDX_W'(i);
            if (m[idx]) p = PRIO_W'(i);
        end
        return p;
    endfunction

endpackage

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter logic [LINES-1:0] TRIG_MASK = 8'hFF,
    parameter bit               MASTER    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  lines,
    input  logic              casc_set,
    input  logic              wr_en,
    input  logic              wr_a0,
    input  logic [7:0]        wr_data,
    input  logic              trig_wr,
    input  logic              rd_en,
    input  logic              rd_a0,
    input  logic              ack_en,
    input  logic [IDX_W-1:0]  ack_irq,
    input  logic              clr2,
    output logic              req_valid,
    output logic [IDX_W-1:0]  req_irq,
    output logic              poll_take,
    output logic [7:0]        rdata,
    output logic [LINES-1:0]  trig_q,
    output logic [BASE_W-1:0] vbase,
    output logic              init_cmd
);

    core_st_t q, d;

    logic [PRIO_W-1:0] p_req, p_cur, p_isr;
    logic [LINES-1:0]  cur_mask, irr_n, edges;
    logic [IDX_W-1:0]  eoi_irq;

    // Request resolution
    always_comb begin
        cur_mask = q.isr;
        if (MASTER && q.sfnm) cur_mask[CASC_LINE] = 1'b0;
        p_req     = prio_of(q.irr & ~q.imr, q.rbase);
        p_cur     = prio_of(cur_mask, q.rbase);
        req_valid = (p_req != NO_PRIO) && (p_req < p_cur);
        req_irq   = p_req[IDX_W-1:0] + q.rbase;
        poll_take = rd_en && q.poll && req_valid;
        if (q.poll)
            rdata = req_valid ? 8'(req_irq) : 8'h07;
        else if (rd_a0)
            rdata = q.imr;
        else
            rdata = q.rsel ? q.isr : q.irr;
        trig_q   = q.trig;
        vbase    = q.vbase;
        init_cmd = wr_en && !wr_a0 && wr_data[4];
    end

    // Next state
    always_comb begin
        d       = q;
        p_isr   = prio_of(q.isr, q.rbase);
        eoi_irq = p_isr[IDX_W-1:0] + q.rbase;

        irr_n = q.irr;
        if (ack_en) begin
            if (!q.trig[ack_irq]) irr_n[ack_irq] = 1'b0;
            if (q.aeoi) begin
                if (q.rot_aeoi) d.rbase = ack_irq + IDX_W'(1);
            end else begin
                d.isr[ack_irq] = 1'b1;
            end
        end

        edges  = lines & ~q.last & ~q.trig;
        irr_n  = (irr_n & ~q.trig) | (lines & q.trig) | edges;
        if (casc_set) irr_n[CASC_LINE] = 1'b1;
        d.last = lines;

        if (rd_en && q.poll) begin
            d.poll = 1'b0;
            if (req_valid) begin
                irr_n[req_irq] = 1'b0;
                d.isr[req_irq] = 1'b0;
            end
        end

        if (clr2) begin
            irr_n[CASC_LINE] = 1'b0;
            d.isr[CASC_LINE] = 1'b0;
        end
        d.irr = irr_n;

        if (trig_wr) d.trig = wr_data & TRIG_MASK;

        if (wr_en) begin
            if (!wr_a0) begin
                if (wr_data[4]) begin
                    d.irr      = '0;
                    d.isr      = '0;
                    d.imr      = '0;
                    d.last     = '0;
                    d.rbase    = '0;
                    d.aeoi     = 1'b0;
                    d.rot_aeoi = 1'b0;
                    d.sfnm     = 1'b0;
                    d.poll     = 1'b0;
                    d.rsel     = 1'b0;
                    d.init_st  = 2'd1;
                    d.init4    = wr_data[0];
                end else if (wr_data[3]) begin
                    if (wr_data[2]) d.poll = 1'b1;
                    if (wr_data[1]) d.rsel = wr_data[0];
                end else begin
                    unique case (wr_data[7:5])
                        3'd0, 3'd4: d.rot_aeoi = wr_data[7];
                        3'd1, 3'd5: begin
                            if (p_isr != NO_PRIO) begin
                                d.isr[eoi_irq] = 1'b0;
                                if (wr_data[7]) d.rbase = eoi_irq + IDX_W'(1);
                            end
                        end
                        3'd3, 3'd7: begin
                            d.isr[wr_data[IDX_W-1:0]] = 1'b0;
                            if (wr_data[7]) d.rbase = wr_data[IDX_W-1:0] + IDX_W'(1);
                        end
                        3'd6:    d.rbase = wr_data[IDX_W-1:0] + IDX_W'(1);
                        default: ;
                    endcase
                end
            end else begin
                unique case (q.init_st)
                    2'd0: d.imr = wr_data;
                    2'd1: begin
                        d.vbase   = wr_data[7:IDX_W];
                        d.init_st = 2'd2;
                    end
                    2'd2: d.init_st = q.init4 ? 2'd3 : 2'd0;
                    default: begin
                        d.sfnm    = wr_data[4];
                        d.aeoi    = wr_data[1];
                        d.init_st = 2'd0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
    import pic_pkg::*;
#(
    parameter logic [LINES-1:0] PRI_TRIG_MASK = 8'hF8,
    parameter logic [LINES-1:0] SEC_TRIG_MASK = 8'hDE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [15:0]  irq_in,
    input  logic         acc_valid,
    input  logic         acc_write,
    input  logic         acc_trig,
    input  logic [1:0]   acc_size,
    input  logic [7:0]   acc_addr,
    input  logic [7:0]   acc_wdata,
    output logic [7:0]   acc_rdata,
    input  logic         ack_req,
    output logic         pend_o,
    output logic         ack_valid,
    output logic         ack_hit,
    output logic [7:0]   ack_vec,
    output logic [3:0]   ack_gsi
);

    arb_st_t q, d;

    logic              acc_ok, ctl_ok, do_ack;
    logic              m_wr, s_wr, m_rd, s_rd, m_trig_wr, s_trig_wr;
    logic              m_valid, s_valid, m_ack, s_ack, casc_set;
    logic [IDX_W-1:0]  m_irq, s_irq;
    logic [7:0]        m_rdata, s_rdata;
    logic [LINES-1:0]  m_trig, s_trig, m_lines;
    logic [BASE_W-1:0] m_vbase, s_vbase;
    logic              m_init, s_init, s_poll_take;
    logic              m_poll_unused, addr_unused;

    assign addr_unused = ^{acc_addr[6:1], irq_in[CASC_LINE]};

    // Access routing
    always_comb begin
        acc_ok    = acc_valid && (acc_size == 2'd0);
        ctl_ok    = acc_ok && !acc_trig;
        m_wr      = ctl_ok && acc_write && !acc_addr[7];
        s_wr      = ctl_ok && acc_write &&  acc_addr[7];
        m_rd      = ctl_ok && !acc_write && !acc_addr[7];
        s_rd      = ctl_ok && !acc_write &&  acc_addr[7];
        m_trig_wr = acc_ok && acc_trig && acc_write && !acc_addr[0];
        s_trig_wr = acc_ok && acc_trig && acc_write &&  acc_addr[0];
        if (!acc_ok)
            acc_rdata = 8'h00;
        else if (acc_trig)
            acc_rdata = acc_addr[0] ? s_trig : m_trig;
        else
            acc_rdata = acc_addr[7] ? s_rdata : m_rdata;
        m_lines            = irq_in[LINES-1:0];
        m_lines[CASC_LINE] = 1'b0;
    end

    // Acknowledge chain
    always_comb begin
        do_ack   = ack_req && q.pend;
        m_ack    = do_ack && m_valid;
        s_ack    = m_ack && (m_irq == IDX_W'(CASC_LINE)) && s_valid;
        casc_set = s_valid && !(m_ack && (m_irq == IDX_W'(CASC_LINE)));

        d           = q;
        d.ack_valid = ack_req;
        d.ack_hit   = do_ack;
        d.vec       = '0;
        d.gsi       = '0;
        if (do_ack) begin
            if (!m_valid) begin
                d.vec = {m_vbase, {IDX_W{1'b1}}};
                d.gsi = {1'b0, {IDX_W{1'b1}}};
            end else if (m_irq == IDX_W'(CASC_LINE)) begin
                if (s_valid) begin
                    d.vec = {s_vbase, s_irq};
                    d.gsi = {1'b1, s_irq};
                end else begin
                    d.vec = {s_vbase, {IDX_W{1'b1}}};
                    d.gsi = {1'b1, {IDX_W{1'b1}}};
                end
            end else begin
                d.vec = {m_vbase, m_irq};
                d.gsi = {1'b0, m_irq};
            end
        end

        if (do_ack || m_init || s_init) d.pend = 1'b0;
        else if (m_valid)               d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o    = q.pend;
    assign ack_valid = q.ack_valid;
    assign ack_hit   = q.ack_hit;
    assign ack_vec   = q.vec;
    assign ack_gsi   = q.gsi;

    pic_core #(.TRIG_MASK(PRI_TRIG_MASK), .MASTER(1'b1)) u_mst (
        .clk(clk), .rst_n(rst_n), .lines(m_lines), .casc_set(casc_set),
        .wr_en(m_wr), .wr_a0(acc_addr[0]), .wr_data(acc_wdata),
        .trig_wr(m_trig_wr), .rd_en(m_rd), .rd_a0(acc_addr[0]),
        .ack_en(m_ack), .ack_irq(m_irq), .clr2(s_poll_take),
        .req_valid(m_valid), .req_irq(m_irq), .poll_take(m_poll_unused),
        .rdata(m_rdata), .trig_q(m_trig), .vbase(m_vbase), .init_cmd(m_init)
    );

    pic_core #(.TRIG_MASK(SEC_TRIG_MASK), .MASTER(1'b0)) u_slv (
        .clk(clk), .rst_n(rst_n), .lines(irq_in[15:8]), .casc_set(1'b0),
        .wr_en(s_wr), .wr_a0(acc_addr[0]), .wr_data(acc_wdata),
        .trig_wr(s_trig_wr), .rd_en(s_rd), .rd_a0(acc_addr[0]),
        .ack_en(s_ack), .ack_irq(s_irq), .clr2(1'b0),
        .req_valid(s_valid), .req_irq(s_irq), .poll_take(s_poll_take),
        .rdata(s_rdata), .trig_q(s_trig), .vbase(s_vbase), .init_cmd(s_init)
    );

endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack_req,
    input logic       pend_o,
    input logic       ack_valid,
    input logic       ack_hit,
    input logic [7:0] ack_vec,
    input logic [3:0] ack_gsi,
    input logic       acc_valid,
    input logic       acc_write,
    input logic       acc_trig,
    input logic [1:0] acc_size,
    input logic [7:0] acc_addr,
    input logic [7:0] acc_wdata,
    input logic [7:0] m_trig,
    input logic [7:0] s_trig,
    input logic       m_valid
);

    p_ack_clears_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req && pend_o |=> !pend_o);

    p_line_matches_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid && ack_hit |-> ack_vec[2:0] == ack_gsi[2:0]);

    p_hit_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid && ack_hit |-> $past(pend_o));

    p_init_clears_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && acc_size == 2'd0 && !acc_trig &&
        !acc_addr[0] && acc_wdata[4] |=> !pend_o);

    p_reject_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_size != 2'd0 |=> $stable(m_trig) && $stable(s_trig));

    p_pend_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !ack_req && !acc_valid |=> pend_o);

endmodule

bind pic_cascade pic_cascade_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .pend_o(pend_o),
    .ack_valid(ack_valid), .ack_hit(ack_hit), .ack_vec(ack_vec),
    .ack_gsi(ack_gsi), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_trig(acc_trig), .acc_size(acc_size), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .m_trig(m_trig), .s_trig(s_trig),
    .m_valid(m_valid)
);

// File: tb/pic_cascade_bench.sv
`timescale 1ns/1ps
module pic_cascade_bench;

    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_trig = 1'b0;
    logic [1:0]  acc_size = 2'd0;
    logic [7:0]  acc_addr = '0, acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic        ack_req = 1'b0;
    logic        pend_o, ack_valid, ack_hit;
    logic [7:0]  ack_vec;
    logic [3:0]  ack_gsi;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0] rv;
    logic       a_vld, a_hit, a_pend;
    logic [7:0] a_vec;
    logic [3:0] a_gsi;

    always #(CLK_NS/2.0) clk = ~clk;

    pic_cascade u_pic_cascade (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_trig(acc_trig),
        .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .ack_req(ack_req), .pend_o(pend_o),
        .ack_valid(ack_valid), .ack_hit(ack_hit), .ack_vec(ack_vec),
        .ack_gsi(ack_gsi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic t, input logic [7:0] a, input logic [7:0] dt,
                          input logic [1:0] sz = 2'd0);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_trig = t;
        acc_addr = a; acc_wdata = dt; acc_size = sz;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_trig = 1'b0; acc_size = 2'd0;
    endtask

    task automatic bus_rd(input logic t, input logic [7:0] a, output logic [7:0] dt);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_trig = t; acc_addr = a; acc_size = 2'd0;
        #1 dt = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0; acc_trig = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        a_vld = ack_valid; a_hit = ack_hit; a_vec = ack_vec;
        a_gsi = ack_gsi; a_pend = pend_o;
    endtask

    task automatic init_all(input logic sfnm);
        irq_in = '0;
        cyc(1);
        bus_wr(1'b1, 8'h00, 8'h00);
        bus_wr(1'b1, 8'h01, 8'h00);
        bus_wr(1'b0, 8'h00, 8'h11);
        bus_wr(1'b0, 8'h01, 8'h20);
        bus_wr(1'b0, 8'h01, 8'h04);
        bus_wr(1'b0, 8'h01, sfnm ? 8'h11 : 8'h01);
        bus_wr(1'b0, 8'h80, 8'h11);
        bus_wr(1'b0, 8'h81, 8'h28);
        bus_wr(1'b0, 8'h81, 8'h02);
        bus_wr(1'b0, 8'h81, 8'h01);
    endtask

    task automatic t_reset();
        chk("R1 pend after reset", pend_o, 1'b0);
        chk("R1 ack_valid after reset", ack_valid, 1'b0);
        bus_rd(1'b0, 8'h00, rv);
        chk("R1 primary request reg", rv, 8'h00);
        bus_rd(1'b0, 8'h01, rv);
        chk("R1 primary mask reg", rv, 8'h00);
    endtask

    task automatic t_master();
        init_all(1'b0);
        irq_in[3] = 1'b1;
        cyc(1);
        chk("R2 pend not yet", pend_o, 1'b0);
        cyc(1);
        chk("R2 pend set", pend_o, 1'b1);
        do_ack();
        chk("R2 ack valid", a_vld, 1'b1);
        chk("R2 ack hit", a_hit, 1'b1);
        chk("R2 vector", a_vec, 8'h23);
        chk("R2 gsi", a_gsi, 4'd3);
        chk("R2 pend consumed", a_pend, 1'b0);
        bus_wr(1'b0, 8'h00, 8'h0B);
        bus_rd(1'b0, 8'h00, rv);
        chk("R13 primary in-service after ack", rv, 8'h08);
        irq_in[3] = 1'b0;
    endtask

    task automatic t_priority();
        init_all(1'b0);
        irq_in[1] = 1'b1; irq_in[6] = 1'b1;
        cyc(2);
        do_ack();
        chk("R2 lowest line wins vec", a_vec, 8'h21);
        chk("R2 lowest line wins gsi", a_gsi, 4'd1);
        cyc(3);
        chk("R12 lower line held off by in-service", pend_o, 1'b0);
        bus_wr(1'b0, 8'h00, 8'h20);
        cyc(1);
        chk("R12 pend re-set after EOI", pend_o, 1'b1);
        do_ack();
        chk("R12 second vector", a_vec, 8'h26);
        chk("R12 second gsi", a_gsi, 4'd6);
        irq_in = '0;
    endtask

    task automatic t_slave();
        init_all(1'b0);
        irq_in[10] = 1'b1;
        cyc(2);
        chk("R3 pend not before cascade", pend_o, 1'b0);
        cyc(1);
        chk("R3 pend via cascade", pend_o, 1'b1);
        do_ack();
        chk("R3 hit", a_hit, 1'b1);
        chk("R3 vector", a_vec, 8'h2A);
        chk("R3 gsi", a_gsi, 4'd10);
        bus_wr(1'b0, 8'h00, 8'h0B);
        bus_rd(1'b0, 8'h00, rv);
        chk("R3 primary in-service bit 2", rv, 8'h04);
        bus_wr(1'b0, 8'h80, 8'h0B);
        bus_rd(1'b0, 8'h80, rv);
        chk("R3 secondary in-service", rv, 8'h04);
        irq_in = '0;
    endtask

    task automatic t_slave_spur();
        init_all(1'b0);
        bus_wr(1'b1, 8'h01, 8'h02);
        irq_in[9] = 1'b1;
        cyc(2);
        irq_in[9] = 1'b0;
        cyc(2);
        chk("R4 pend set", pend_o, 1'b1);
        do_ack();
        chk("R4 spurious vector", a_vec, 8'h2F);
        chk("R4 spurious gsi", a_gsi, 4'd15);
        bus_wr(1'b0, 8'h80, 8'h0B);
        bus_rd(1'b0, 8'h80, rv);
        chk("R4 secondary in-service untouched", rv, 8'h00);
    endtask

    task automatic t_master_spur();
        init_all(1'b0);
        bus_wr(1'b1, 8'h00, 8'h08);
        irq_in[3] = 1'b1;
        cyc(2);
        chk("R5 pend set", pend_o, 1'b1);
        irq_in[3] = 1'b0;
        cyc(1);
        do_ack();
        chk("R5 spurious vector", a_vec, 8'h27);
        chk("R5 spurious gsi", a_gsi, 4'd7);
        bus_wr(1'b0, 8'h00, 8'h0B);
        bus_rd(1'b0, 8'h00, rv);
        chk("R5 primary in-service untouched", rv, 8'h00);
    endtask

    task automatic t_no_pend();
        init_all(1'b0);
        do_ack();
        chk("R6 ack valid", a_vld, 1'b1);
        chk("R6 no hit", a_hit, 1'b0);
        chk("R6 vector zero", a_vec, 8'h00);
        chk("R6 gsi zero", a_gsi, 4'd0);
        bus_wr(1'b0, 8'h00, 8'h0B);
        bus_rd(1'b0, 8'h00, rv);
        chk("R6 in-service unchanged", rv, 8'h00);
    endtask

    task automatic t_init_clear();
        init_all(1'b0);
        irq_in[4] = 1'b1;
        cyc(2);
        chk("R7 pend set first", pend_o, 1'b1);
        bus_wr(1'b0, 8'h80, 8'h11);
        chk("R7 init clears pend", pend_o, 1'b0);
        irq_in = '0;
    endtask

    task automatic t_nest(input logic sfnm);
        init_all(sfnm);
        irq_in[10] = 1'b1;
        cyc(3);
        do_ack();
        chk("R8 first nested gsi", a_gsi, 4'd10);
        irq_in[8] = 1'b1;
        cyc(4);
        if (sfnm) begin
            chk("R8 special nesting lets line 8 pass", pend_o, 1'b1);
            do_ack();
            chk("R8 nested vector", a_vec, 8'h28);
            chk("R8 nested gsi", a_gsi, 4'd8);
        end else begin
            chk("R8 plain nesting blocks line 8", pend_o, 1'b0);
        end
        irq_in = '0;
    endtask

    task automatic t_poll();
        init_all(1'b0);
        irq_in[11] = 1'b1;
        cyc(3);
        bus_wr(1'b0, 8'h80, 8'h0C);
        bus_rd(1'b0, 8'h80, rv);
        chk("R9 poll returns line", rv, 8'h03);
        bus_rd(1'b0, 8'h00, rv);
        chk("R9 primary request bit 2 cleared", rv, 8'h00);
        bus_rd(1'b0, 8'h80, rv);
        chk("R9 secondary request cleared", rv, 8'h00);
        bus_wr(1'b0, 8'h80, 8'h0C);
        bus_rd(1'b0, 8'h80, rv);
        chk("R9 empty poll", rv, 8'h07);
        irq_in = '0;
    endtask

    task automatic t_route();
        init_all(1'b0);
        bus_wr(1'b0, 8'h01, 8'h5A);
        bus_wr(1'b0, 8'h81, 8'hA5);
        bus_rd(1'b0, 8'h01, rv);
        chk("R10 primary mask", rv, 8'h5A);
        bus_rd(1'b0, 8'h81, rv);
        chk("R10 secondary mask", rv, 8'hA5);
        bus_wr(1'b1, 8'h00, 8'hFF);
        bus_wr(1'b1, 8'h01, 8'hFF);
        bus_rd(1'b1, 8'h00, rv);
        chk("R10 primary trigger mask", rv, 8'hF8);
        bus_rd(1'b1, 8'h01, rv);
        chk("R10 secondary trigger mask", rv, 8'hDE);
        bus_wr(1'b0, 8'h01, 8'h33, 2'd1);
        bus_rd(1'b0, 8'h01, rv);
        chk("R11 wide mask write ignored", rv, 8'h5A);
        bus_wr(1'b1, 8'h00, 8'h00, 2'd2);
        bus_rd(1'b1, 8'h00, rv);
        chk("R11 wide trigger write ignored", rv, 8'hF8);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 8'h01; acc_size = 2'd1;
        #1 rv = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0; acc_size = 2'd0;
        chk("R11 wide read returns zero", rv, 8'h00);
    endtask

    initial begin
        #(CLK_NS * 200000.0);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_master();
        t_priority();
        t_slave();
        t_slave_spur();
        t_master_spur();
        t_no_pend();
        t_init_clear();
        t_nest(1'b0);
        t_nest(1'b1);
        t_poll();
        t_route();
        cyc(2);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule